// File: doc/BRIEF.md
# Link L1 Power-State Controller

This block sequences one port of a serial point-to-point link into and out of the L1 low-power state. It keeps two kinds of L1 residency apart: L1 reached autonomously by hardware negotiation, and L1 ordered by software. Autonomous entry is a request/acknowledge exchange of link-layer packets. The port can play either side of that exchange, chosen by a role input. Once both sides agree, each side sends an electrical-idle ordered set and drops into electrical idle.

Leaving L1 takes an electrical-idle-exit ordered set followed by TS1 ordered sets. The controller returns to the active state once a programmed number of TS1 sets has come back from the partner.

A wake arriving from the upstream side ends autonomous L1 but leaves software-directed L1 in place. A wake raised on the local side ends either kind of L1 and pulses a propagation output, so that every link on the path toward the root also wakes.

Top module: `lpm_l1_ctrl`

## Requirements
- R1: After reset the state output reads ACTIVE (0), and `txValid`, `elecIdle` and `wakeOut` are all 0.
- R2: On the downstream side (`isUpstream`=0) with `aspmL1En`=1, the controller behaves as follows:
  - It starts entry once `linkIdle` has been high for `idleThresh` consecutive cycles.
  - On the next clock it moves to REQ_SENT (1) and transmits one L1-request symbol (code 1).
  - A low cycle on `linkIdle` restarts the count.
- R3: With `aspmL1En`=0 no autonomous entry happens on either side. The state stays ACTIVE and nothing is transmitted, however long the link is idle. An incoming L1 request gets no reply.
- R4: In REQ_SENT, a received acknowledge (code 2) moves the state to ACKED (2) with one EIOS (code 3) transmitted. In ACKED, a received EIOS moves the state to IDLE_ASPM (3) with `elecIdle`=1.
- R5: When no acknowledge arrives, the state stays REQ_SENT for `ackTimeout` cycles after entering it and then falls back to ACTIVE. The idle count must then be requalified from zero.
- R6: On the upstream side (`isUpstream`=1) with `aspmL1En`=1, a received L1 request moves the state to ACKED and transmits an acknowledge (code 2). A following received EIOS makes it transmit EIOS and enter IDLE_ASPM with `elecIdle`=1.
- R7: In ACTIVE, `swL1Req`=1 moves the state to IDLE_PCIPM (4), transmits EIOS and sets `elecIdle`.
- R8: `upWake` in IDLE_ASPM moves the state to EXITING (5), clears `elecIdle` and transmits EIEOS (code 4). From the next cycle it transmits TS1 (code 5) every cycle. `upWake` in IDLE_PCIPM is ignored: the state, `elecIdle` and the transmitter are unchanged.
- R9: `localWake` in either L1 state moves the state to EXITING and raises `wakeOut` for exactly the first cycle of EXITING. An exit started by `upWake` leaves `wakeOut` low.
- R10: In EXITING, once `ts1Count` TS1 symbols (code 5) have been received, the state returns to ACTIVE on the next clock and transmission stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isUpstream | input | 1 | 1: port acts as the upstream (acknowledging) side |
| aspmL1En | input | 1 | Link-control enable bit for autonomous L1 |
| swL1Req | input | 1 | Software order to enter L1 |
| linkIdle | input | 1 | Idle-detect from the link layer |
| rxValid | input | 1 | A received symbol is present |
| rxType | input | 3 | Received symbol code (1 L1 request, 2 ack, 3 EIOS, 4 EIEOS, 5 TS1) |
| localWake | input | 1 | Wake request from the local side |
| upWake | input | 1 | Exit started from the upstream side |
| idleThresh | input | IDLE_W | Idle cycles required before entry |
| ackTimeout | input | TO_W | Cycles to wait for an acknowledge or EIOS |
| ts1Count | input | TS_W | TS1 symbols needed to finish exit |
| txValid | output | 1 | A symbol is being transmitted |
| txType | output | 3 | Transmitted symbol code, same coding as rxType |
| elecIdle | output | 1 | Transmitter held in electrical idle |
| state | output | 3 | Current state code |
| wakeOut | output | 1 | One-cycle wake pulse toward the root |

## Verification
The entry path is driven with an unbroken idle run and with a run split by one busy cycle. The split run shows whether the idle count truly restarts or only pauses. Entry is tried with the L1 bit both set and clear, and in both roles, which separates the requesting side from the acknowledging side and shows that a refused request produces no traffic. Exits are started by the upstream wake and by the local wake from both autonomous and software L1, which tells apart the two residencies and the cases that must or must not pulse the propagation output. A request left unanswered exercises the timeout and the requalification that follows it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE     = 3'd0,
    ST_REQ_SENT   = 3'd1,
    ST_ACKED      = 3'd2,
    ST_IDLE_ASPM  = 3'd3,
    ST_IDLE_PCIPM = 3'd4,
    ST_EXITING    = 3'd5
  } lpmState_e;

  typedef enum logic [2:0] {
    SYM_NONE  = 3'd0,
    SYM_L1REQ = 3'd1,
    SYM_ACK   = 3'd2,
    SYM_EIOS  = 3'd3,
    SYM_EIEOS = 3'd4,
    SYM_TS1   = 3'd5
  } lpmSym_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    idleClr;
    logic    toClr;
    logic    tsClr;
    logic    txEn;
    lpmSym_e txSym;
    logic    eiSet;
    logic    eiClr;
    logic    wakePulse;
  } lpmStrobe_t;

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int IDLE_W = 8,
  parameter int TO_W   = 8,
  parameter int TS_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpmStrobe_t        strobe,
  input  logic              linkIdle,
  input  logic              rxValid,
  input  logic [2:0]        rxType,
  input  logic [IDLE_W-1:0] idleThresh,
  input  logic [TO_W-1:0]   ackTimeout,
  input  logic [TS_W-1:0]   ts1Count,
  output logic              idleHit,
  output logic              toHit,
  output logic              tsDone,
  output logic              txValid,
  output logic [2:0]        txType,
  output logic              elecIdle,
  output logic              wakeOut
);

  localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};
  localparam logic [TO_W-1:0]   TO_MAX   = {TO_W{1'b1}};
  localparam logic [TS_W-1:0]   TS_MAX   = {TS_W{1'b1}};

  logic [IDLE_W-1:0] idleCnt;
  logic [TO_W-1:0]   toCnt;
  logic [TS_W-1:0]   tsCnt;
  logic              rxTs1;

  assign rxTs1 = rxValid && (rxType == SYM_TS1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobe.idleClr || !linkIdle) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (strobe.toClr) begin
      toCnt <= '0;
    end else if (toCnt != TO_MAX) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsCnt <= '0;
    end else if (strobe.tsClr) begin
      tsCnt <= '0;
    end else if (rxTs1 && tsCnt != TS_MAX) begin
      tsCnt <= tsCnt + 1'b1;
    end
  end

  assign idleHit = linkIdle && (idleCnt >= idleThresh);
  assign toHit   = toCnt >= ackTimeout;
  assign tsDone  = tsCnt >= ts1Count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid  <= 1'b0;
      txType   <= SYM_NONE;
      elecIdle <= 1'b0;
      wakeOut  <= 1'b0;
    end else begin
      txValid <= strobe.txEn;
      txType  <= strobe.txEn ? strobe.txSym : SYM_NONE;
      wakeOut <= strobe.wakePulse;
      if (strobe.eiSet)      elecIdle <= 1'b1;
      else if (strobe.eiClr) elecIdle <= 1'b0;
    end
  end

  // the idle count never jumps by more than one per cycle
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt != '0) |-> ($past(idleCnt) == idleCnt - 1'b1) || (idleCnt == IDLE_MAX)); // R2

endmodule

// File: rtl/lpm_ctrl_fsm.sv
module lpm_ctrl_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       isUpstream,
  input  logic       aspmL1En,
  input  logic       swL1Req,
  input  logic       rxValid,
  input  logic [2:0] rxType,
  input  logic       localWake,
  input  logic       upWake,
  input  logic       idleHit,
  input  logic       toHit,
  input  logic       tsDone,
  output lpmState_e  curState,
  output lpmStrobe_t strobe
);

  lpmState_e nextState;
  logic      rxReq, rxAck, rxEios;

  assign rxReq  = rxValid && (rxType == SYM_L1REQ);
  assign rxAck  = rxValid && (rxType == SYM_ACK);
  assign rxEios = rxValid && (rxType == SYM_EIOS);

  always_comb begin
    nextState      = curState;
    strobe         = '0;
    strobe.txSym   = SYM_NONE;
    strobe.idleClr = (curState != ST_ACTIVE);
    unique case (curState)
      ST_ACTIVE: begin
        if (swL1Req) begin
          nextState    = ST_IDLE_PCIPM;
          strobe.txEn  = 1'b1;
          strobe.txSym = SYM_EIOS;
          strobe.eiSet = 1'b1;
        end else if (aspmL1En && !isUpstream && idleHit) begin
          nextState    = ST_REQ_SENT;
          strobe.txEn  = 1'b1;
          strobe.txSym = SYM_L1REQ;
          strobe.toClr = 1'b1;
        end else if (aspmL1En && isUpstream && rxReq) begin
          nextState    = ST_ACKED;
          strobe.txEn  = 1'b1;
          strobe.txSym = SYM_ACK;
          strobe.toClr = 1'b1;
        end
      end
      ST_REQ_SENT: begin
        if (rxAck) begin
          nextState    = ST_ACKED;
          strobe.txEn  = 1'b1;
          strobe.txSym = SYM_EIOS;
          strobe.toClr = 1'b1;
        end else if (toHit) begin
          nextState = ST_ACTIVE;
        end
      end
      ST_ACKED: begin
        if (rxEios) begin
          nextState    = ST_IDLE_ASPM;
          strobe.eiSet = 1'b1;
          if (isUpstream) begin
            strobe.txEn  = 1'b1;
            strobe.txSym = SYM_EIOS;
          end
        end else if (toHit) begin
          nextState = ST_ACTIVE;
        end
      end
      ST_IDLE_ASPM: begin
        if (localWake || upWake) begin
          nextState        = ST_EXITING;
          strobe.txEn      = 1'b1;
          strobe.txSym     = SYM_EIEOS;
          strobe.eiClr     = 1'b1;
          strobe.tsClr     = 1'b1;
          strobe.wakePulse = localWake;
        end
      end
      ST_IDLE_PCIPM: begin
        if (localWake) begin
          nextState        = ST_EXITING;
          strobe.txEn      = 1'b1;
          strobe.txSym     = SYM_EIEOS;
          strobe.eiClr     = 1'b1;
          strobe.tsClr     = 1'b1;
          strobe.wakePulse = 1'b1;
        end
      end
      ST_EXITING: begin
        if (tsDone) begin
          nextState = ST_ACTIVE;
        end else begin
          strobe.txEn  = 1'b1;
          strobe.txSym = SYM_TS1;
        end
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_ACTIVE;
    else       curState <= nextState;
  end

  AST_NO_ENTRY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ACTIVE && !aspmL1En && !swL1Req) |=> (curState == ST_ACTIVE)); // R3

  AST_PCIPM_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE_PCIPM && !localWake) |=> (curState == ST_IDLE_PCIPM)); // R8

  AST_EXIT_FROM_L1: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_EXITING && $past(curState) != ST_EXITING) |->
      ($past(curState) == ST_IDLE_ASPM || $past(curState) == ST_IDLE_PCIPM)); // R9

endmodule

// File: rtl/lpm_l1_ctrl.sv
module lpm_l1_ctrl
  import lpm_pkg::*;
#(
  parameter int IDLE_W = 8,
  parameter int TO_W   = 8,
  parameter int TS_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isUpstream,
  input  logic              aspmL1En,
  input  logic              swL1Req,
  input  logic              linkIdle,
  input  logic              rxValid,
  input  logic [2:0]        rxType,
  input  logic              localWake,
  input  logic              upWake,
  input  logic [IDLE_W-1:0] idleThresh,
  input  logic [TO_W-1:0]   ackTimeout,
  input  logic [TS_W-1:0]   ts1Count,
  output logic              txValid,
  output logic [2:0]        txType,
  output logic              elecIdle,
  output logic [2:0]        state,
  output logic              wakeOut
);

  lpmState_e  curState;
  lpmStrobe_t strobe;
  logic       idleHit, toHit, tsDone;

  lpm_ctrl_fsm u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .isUpstream (isUpstream),
    .aspmL1En   (aspmL1En),
    .swL1Req    (swL1Req),
    .rxValid    (rxValid),
    .rxType     (rxType),
    .localWake  (localWake),
    .upWake     (upWake),
    .idleHit    (idleHit),
    .toHit      (toHit),
    .tsDone     (tsDone),
    .curState   (curState),
    .strobe     (strobe)
  );

  lpm_datapath #(
    .IDLE_W (IDLE_W),
    .TO_W   (TO_W),
    .TS_W   (TS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .linkIdle   (linkIdle),
    .rxValid    (rxValid),
    .rxType     (rxType),
    .idleThresh (idleThresh),
    .ackTimeout (ackTimeout),
    .ts1Count   (ts1Count),
    .idleHit    (idleHit),
    .toHit      (toHit),
    .tsDone     (tsDone),
    .txValid    (txValid),
    .txType     (txType),
    .elecIdle   (elecIdle),
    .wakeOut    (wakeOut)
  );

  assign state = curState;

  AST_EI_MATCHES_L1: assert property (@(posedge clk) disable iff (!rstN)
    elecIdle == (curState == ST_IDLE_ASPM || curState == ST_IDLE_PCIPM)); // R4

  AST_WAKE_LOCAL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> ($past(localWake) && curState == ST_EXITING)); // R9

  AST_REQ_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txType == SYM_L1REQ) |-> ($past(!isUpstream) && curState == ST_REQ_SENT)); // R2

endmodule

// File: tb/sim_lpm_l1_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_l1_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       isUpstream = 1'b0, aspmL1En = 1'b0, swL1Req = 1'b0, linkIdle = 1'b0;
  logic       rxValid = 1'b0, localWake = 1'b0, upWake = 1'b0;
  logic [2:0] rxType = 3'd0;
  logic [7:0] idleThresh = 8'd4;
  logic [7:0] ackTimeout = 8'd6;
  logic [3:0] ts1Count = 4'd3;
  logic       txValid, elecIdle, wakeOut;
  logic [2:0] txType, state;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lpm_l1_ctrl u0 (
    .clk(clk), .rstN(rstN), .isUpstream(isUpstream), .aspmL1En(aspmL1En),
    .swL1Req(swL1Req), .linkIdle(linkIdle), .rxValid(rxValid), .rxType(rxType),
    .localWake(localWake), .upWake(upWake), .idleThresh(idleThresh),
    .ackTimeout(ackTimeout), .ts1Count(ts1Count), .txValid(txValid),
    .txType(txType), .elecIdle(elecIdle), .state(state), .wakeOut(wakeOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rxOne(input logic [2:0] code);
    rxValid = 1'b1; rxType = code;
    cyc(1);
    rxValid = 1'b0; rxType = 3'd0;
  endtask

  task automatic finishExit(input string req);
    rxValid = 1'b1; rxType = 3'd5;
    cyc(3);
    rxValid = 1'b0; rxType = 3'd0;
    chk(req, "state after last TS1", state, 5);
    cyc(1);
    chk("R10", "state back", state, 0);
    chk("R10", "txValid back", txValid, 0);
  endtask

  task automatic tReset();
    chk("R1", "state", state, 0);
    chk("R1", "txValid", txValid, 0);
    chk("R1", "elecIdle", elecIdle, 0);
    chk("R1", "wakeOut", wakeOut, 0);
  endtask

  task automatic tDownEntry();
    isUpstream = 1'b0; aspmL1En = 1'b1;
    linkIdle = 1'b1; cyc(3);
    linkIdle = 1'b0; cyc(1);
    linkIdle = 1'b1; cyc(4);
    chk("R2", "state before threshold", state, 0);
    cyc(1);
    chk("R2", "state REQ_SENT", state, 1);
    chk("R2", "txType L1 request", txType, 1);
    chk("R2", "txValid", txValid, 1);
    linkIdle = 1'b0;
    rxOne(3'd2);
    chk("R4", "state ACKED", state, 2);
    chk("R4", "txType EIOS", txType, 3);
    chk("R4", "elecIdle in ACKED", elecIdle, 0);
    rxOne(3'd3);
    chk("R4", "state IDLE_ASPM", state, 3);
    chk("R4", "elecIdle", elecIdle, 1);
    upWake = 1'b1; cyc(1); upWake = 1'b0;
    chk("R8", "state EXITING", state, 5);
    chk("R8", "txType EIEOS", txType, 4);
    chk("R8", "elecIdle cleared", elecIdle, 0);
    chk("R9", "no wakeOut on up wake", wakeOut, 0);
    cyc(1);
    chk("R8", "txType TS1", txType, 5);
    finishExit("R10");
  endtask

  task automatic tTimeout();
    isUpstream = 1'b0; aspmL1En = 1'b1;
    linkIdle = 1'b1; cyc(5);
    chk("R5", "state REQ_SENT", state, 1);
    cyc(6);
    chk("R5", "still waiting", state, 1);
    cyc(1);
    chk("R5", "abandon to ACTIVE", state, 0);
    cyc(4);
    chk("R5", "idle requalified", state, 0);
    linkIdle = 1'b0; cyc(1);
  endtask

  task automatic tDisabled();
    aspmL1En = 1'b0; isUpstream = 1'b0;
    linkIdle = 1'b1; cyc(12);
    chk("R3", "down no entry", state, 0);
    chk("R3", "down no tx", txValid, 0);
    linkIdle = 1'b0;
    isUpstream = 1'b1;
    rxOne(3'd1);
    chk("R3", "up no entry", state, 0);
    chk("R3", "up no ack", txValid, 0);
  endtask

  task automatic tUpEntry();
    isUpstream = 1'b1; aspmL1En = 1'b1;
    rxOne(3'd1);
    chk("R6", "state ACKED", state, 2);
    chk("R6", "txType ack", txType, 2);
    rxOne(3'd3);
    chk("R6", "state IDLE_ASPM", state, 3);
    chk("R6", "txType EIOS", txType, 3);
    chk("R6", "elecIdle", elecIdle, 1);
    localWake = 1'b1; cyc(1); localWake = 1'b0;
    chk("R9", "state EXITING", state, 5);
    chk("R9", "wakeOut pulse", wakeOut, 1);
    cyc(1);
    chk("R9", "wakeOut one cycle", wakeOut, 0);
    finishExit("R10");
  endtask

  task automatic tSoftware();
    isUpstream = 1'b0; aspmL1En = 1'b1;
    swL1Req = 1'b1; cyc(1); swL1Req = 1'b0;
    chk("R7", "state IDLE_PCIPM", state, 4);
    chk("R7", "txType EIOS", txType, 3);
    chk("R7", "elecIdle", elecIdle, 1);
    cyc(1);
    upWake = 1'b1; cyc(1); upWake = 1'b0;
    chk("R8", "up wake ignored state", state, 4);
    chk("R8", "up wake ignored tx", txValid, 0);
    chk("R8", "up wake ignored elecIdle", elecIdle, 1);
    localWake = 1'b1; cyc(1); localWake = 1'b0;
    chk("R9", "state EXITING", state, 5);
    chk("R9", "wakeOut pulse", wakeOut, 1);
    finishExit("R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tDownEntry();
    tTimeout();
    tDisabled();
    tUpEntry();
    tSoftware();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule